// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two predictors side by side. The first is a global correlating predictor: one shift register records the outcomes of the latest branches across the whole processor, and that history, optionally XOR-folded with the branch address, selects one counter in a shared array of 2-bit counters. The second is a two-level local predictor. A table indexed by branch address keeps each branch's own outcome history, and that history alone selects a counter in a second shared array, so branches that show the same recent pattern train the same counter.

A third array of 2-bit counters, the chooser, is indexed by the global history. For each lookup it decides which of the two predictors to follow. It is trained only when the two predictors disagree, and it moves toward whichever one was right.

A lookup is combinational: an address goes in and a direction comes out, based on the state held at that moment. An update presents the branch address and its real outcome. On the next clock edge, both predictors and the chooser are trained, and then the outcome is shifted into the global history and into that branch's local history. Histories are updated only with resolved outcomes. Speculative history and its repair are left to the surrounding pipeline.

Top module: `tbp_predictor`

## Requirements
- R1: After reset, every component counter and every chooser counter holds 1 (weakly not taken, chooser favouring the local predictor), and every history is zero, so every lookup returns not taken.
- R2: Each update shifts the actual outcome (1 = taken) into bit 0 of the global history, and the older bits move up one place. Without an update the global history keeps its value.
- R3: With HASH_EN = 1 the global counter index is the global history XOR the low GHIST_W address bits. With HASH_EN = 0 it is the global history alone.
- R4: The local history table is indexed by the low LHT_IDX_W address bits. An update shifts the outcome into bit 0 of the entry for that address.
- R5: The local counter array is indexed only by the branch's local history, so two branches with equal histories read and train the same counter.
- R6: Every counter is 2 bits wide. It counts up on taken and down on not taken, it saturates at 0 and 3, and it predicts taken when its value is 2 or 3.
- R7: The chooser counter at the current global history selects the global prediction when its value is 2 or 3, and the local prediction otherwise. It changes only when the two component predictions differ, counting up when the global one was correct and down when the local one was correct.
- R8: A lookup reflects the state before any update presented in the same cycle. An update takes effect on the following cycle. With no update the prediction for a fixed address does not change.
- R9: On each update both component counters are trained, using indices formed from the histories as they stood before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | ADDR_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest situation to reach from the ports is a chooser flip. It needs the two component predictors to disagree repeatedly at the same global history value, with the same one being right each time. Uniform traces never produce that. The bench therefore runs a loop-style trace, an alternating trace, and two addresses that build the same local pattern. Under those traces the local predictor and the global predictor part ways at recurring history values. An independent model in the bench tracks every table, so every lookup along the traces is compared against it, including the ones right after the chooser crosses its threshold.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef logic [1:0] ctr2_t;
   localparam ctr2_t CTR_RESET = 2'd1;

   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t r;
      r = c;
      if (up && c != 2'd3) r = c + 2'd1;
      else if (!up && c != 2'd0) r = c - 2'd1;
      return r;
   endfunction

   function automatic logic ctr_dir(input ctr2_t c);
      return c[1];
   endfunction
endpackage

// File: rtl/tbp_global.sv
module tbp_global
   import tbp_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int GHIST_W = 8,
   parameter bit HASH_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  pred_addr,
   input  logic               upd_valid,
   input  logic [ADDR_W-1:0]  upd_addr,
   input  logic               upd_taken,
   output logic               pred_dir,
   output logic               upd_dir,
   output logic [GHIST_W-1:0] ghist
);
   localparam int DEPTH = 1 << GHIST_W;

   ctr2_t              ctr_q [DEPTH];
   logic [GHIST_W-1:0] pidx;
   logic [GHIST_W-1:0] uidx;

   generate
      if (HASH_EN) begin : g_hash
         assign pidx = ghist ^ pred_addr[GHIST_W-1:0];
         assign uidx = ghist ^ upd_addr[GHIST_W-1:0];
      end else begin : g_plain
         assign pidx = ghist;
         assign uidx = ghist;
      end
   endgenerate

   assign pred_dir = ctr_dir(ctr_q[pidx]);
   assign upd_dir  = ctr_dir(ctr_q[uidx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ghist <= '0;
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
      end else if (upd_valid) begin
         ctr_q[uidx] <= ctr_step(ctr_q[uidx], upd_taken);
         ghist       <= {ghist[GHIST_W-2:0], upd_taken};
      end
   end
endmodule

// File: rtl/tbp_local.sv
module tbp_local
   import tbp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LHT_IDX_W = 6,
   parameter int LHIST_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken,
   output logic              pred_dir,
   output logic              upd_dir
);
   localparam int LHT_DEPTH = 1 << LHT_IDX_W;
   localparam int CTR_DEPTH = 1 << LHIST_W;

   logic [LHIST_W-1:0]   hist_q [LHT_DEPTH];
   ctr2_t                ctr_q  [CTR_DEPTH];
   logic [LHT_IDX_W-1:0] p_slot;
   logic [LHT_IDX_W-1:0] u_slot;
   logic [LHIST_W-1:0]   p_hist;
   logic [LHIST_W-1:0]   u_hist;

   assign p_slot   = pred_addr[LHT_IDX_W-1:0];
   assign u_slot   = upd_addr[LHT_IDX_W-1:0];
   assign p_hist   = hist_q[p_slot];
   assign u_hist   = hist_q[u_slot];
   assign pred_dir = ctr_dir(ctr_q[p_hist]);
   assign upd_dir  = ctr_dir(ctr_q[u_hist]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LHT_DEPTH; i++) hist_q[i] <= '0;
         for (int j = 0; j < CTR_DEPTH; j++) ctr_q[j] <= CTR_RESET;
      end else if (upd_valid) begin
         ctr_q[u_hist]  <= ctr_step(ctr_q[u_hist], upd_taken);
         hist_q[u_slot] <= {u_hist[LHIST_W-2:0], upd_taken};
      end
   end
endmodule

// File: rtl/tbp_chooser.sv
module tbp_chooser
   import tbp_pkg::*;
#(
   parameter int GHIST_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GHIST_W-1:0] ghist,
   input  logic               upd_valid,
   input  logic               upd_taken,
   input  logic               upd_glob_dir,
   input  logic               upd_loc_dir,
   output logic               use_global
);
   localparam int DEPTH = 1 << GHIST_W;

   ctr2_t ctr_q [DEPTH];
   logic  differ;

   assign use_global = ctr_dir(ctr_q[ghist]);
   assign differ     = upd_glob_dir != upd_loc_dir;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
      end else if (upd_valid && differ) begin
         ctr_q[ghist] <= ctr_step(ctr_q[ghist], upd_glob_dir == upd_taken);
      end
   end
endmodule

// File: rtl/tbp_predictor.sv
module tbp_predictor #(
   parameter int ADDR_W    = 16,
   parameter int GHIST_W   = 8,
   parameter int LHT_IDX_W = 6,
   parameter int LHIST_W   = 6,
   parameter bit HASH_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken
);
   generate
      if (GHIST_W < 2 || GHIST_W > ADDR_W) begin : g_bad_ghist
         $error("tbp_predictor: GHIST_W must be in 2..ADDR_W");
      end
      if (LHIST_W < 2) begin : g_bad_lhist
         $error("tbp_predictor: LHIST_W must be at least 2");
      end
      if (LHT_IDX_W < 1 || LHT_IDX_W > ADDR_W) begin : g_bad_lht
         $error("tbp_predictor: LHT_IDX_W must be in 1..ADDR_W");
      end
   endgenerate

   logic               g_pred, g_upd;
   logic               l_pred, l_upd;
   logic               sel_glob;
   logic [GHIST_W-1:0] ghist_w;

   tbp_global #(.ADDR_W(ADDR_W), .GHIST_W(GHIST_W), .HASH_EN(HASH_EN)) glob_i (
      .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
      .pred_dir(g_pred), .upd_dir(g_upd), .ghist(ghist_w));

   tbp_local #(.ADDR_W(ADDR_W), .LHT_IDX_W(LHT_IDX_W), .LHIST_W(LHIST_W)) loc_i (
      .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
      .pred_dir(l_pred), .upd_dir(l_upd));

   tbp_chooser #(.GHIST_W(GHIST_W)) cho_i (
      .clk(clk), .rst_n(rst_n), .ghist(ghist_w),
      .upd_valid(upd_valid), .upd_taken(upd_taken),
      .upd_glob_dir(g_upd), .upd_loc_dir(l_upd), .use_global(sel_glob));

   assign pred_taken = sel_glob ? g_pred : l_pred;
endmodule

// File: rtl/tbp_predictor_chk.sv
module tbp_predictor_chk #(
   parameter int ADDR_W  = 16,
   parameter int GHIST_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  pred_addr,
   input logic               pred_taken,
   input logic               upd_valid,
   input logic               upd_taken,
   input logic [GHIST_W-1:0] ghist
);
   AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !pred_taken); // R1

   AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}); // R2

   AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghist)); // R2

   AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(upd_valid) && $stable(pred_addr)) |-> $stable(pred_taken)); // R8
endmodule

bind tbp_predictor tbp_predictor_chk #(.ADDR_W(ADDR_W), .GHIST_W(GHIST_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
   .upd_valid(upd_valid), .upd_taken(upd_taken), .ghist(ghist_w));

// File: tb/tbp_predictor_tb_top.sv
module tbp_predictor_tb_top;
   localparam int AW = 16;
   localparam int GW = 8;
   localparam int LI = 6;
   localparam int LH = 6;
   localparam bit HS = 1'b1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] pred_addr = '0;
   logic          pred_taken;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_addr = '0;
   logic          upd_taken = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   tbp_predictor #(.ADDR_W(AW), .GHIST_W(GW), .LHT_IDX_W(LI), .LHIST_W(LH), .HASH_EN(HS)) dut_i (
      .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

   // Reference model state
   logic [1:0]    m_g   [1<<GW];
   logic [1:0]    m_c   [1<<GW];
   logic [LH-1:0] m_lht [1<<LI];
   logic [1:0]    m_l   [1<<LH];
   logic [GW-1:0] m_gh;

   function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   function automatic int gidx(input logic [AW-1:0] a);
      return HS ? int'(m_gh ^ a[GW-1:0]) : int'(m_gh);
   endfunction

   function automatic logic m_gdir(input logic [AW-1:0] a);
      return m_g[gidx(a)] >= 2'd2;
   endfunction

   function automatic logic m_ldir(input logic [AW-1:0] a);
      return m_l[m_lht[a[LI-1:0]]] >= 2'd2;
   endfunction

   function automatic logic m_predict(input logic [AW-1:0] a);
      return (m_c[m_gh] >= 2'd2) ? m_gdir(a) : m_ldir(a);
   endfunction

   task automatic m_reset();
      for (int i = 0; i < (1<<GW); i++) begin m_g[i] = 2'd1; m_c[i] = 2'd1; end
      for (int i = 0; i < (1<<LI); i++) m_lht[i] = '0;
      for (int i = 0; i < (1<<LH); i++) m_l[i] = 2'd1;
      m_gh = '0;
   endtask

   task automatic m_update(input logic [AW-1:0] a, input logic t);
      logic gd, ld;
      logic [LH-1:0] h;
      gd = m_gdir(a);
      ld = m_ldir(a);
      h  = m_lht[a[LI-1:0]];
      if (gd != ld) m_c[m_gh] = sat(m_c[m_gh], gd == t);
      m_g[gidx(a)] = sat(m_g[gidx(a)], t);
      m_l[h] = sat(m_l[h], t);
      m_lht[a[LI-1:0]] = {h[LH-2:0], t};
      m_gh = {m_gh[GW-2:0], t};
   endtask

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: pred_taken=%0b expected=%0b", req, act, exp);
      end
   endtask

   // One lookup-then-update step on a single branch
   task automatic step(input logic [AW-1:0] a, input logic t, input string req);
      @(negedge clk);
      upd_valid = 1'b0;
      pred_addr = a;
      #1;
      check(pred_taken, m_predict(a), req);
      upd_addr  = a;
      upd_taken = t;
      upd_valid = 1'b1;
      @(posedge clk);
      m_update(a, t);
      #1 upd_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      upd_valid = 1'b0;
      repeat (3) @(posedge clk);
      m_reset();
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         pred_addr = AW'(i * 37 + 5);
         #1 check(pred_taken, 1'b0, "R1 reset lookup");
      end
   endtask

   task automatic t_loop_trace();
      do_reset();
      for (int rep = 0; rep < 12; rep++)
         for (int k = 0; k < 8; k++)
            step(16'h0040, k != 7, "R6 R7 R9 loop trace");
   endtask

   task automatic t_alternating();
      do_reset();
      for (int k = 0; k < 80; k++)
         step(16'h0123, k[0], "R4 R7 alternating");
   endtask

   task automatic t_shared_pattern();
      do_reset();
      for (int k = 0; k < 24; k++) step(16'h0011, (k % 3) != 0, "R5 shared A");
      for (int k = 0; k < 24; k++) step(16'h0022, (k % 3) != 0, "R5 shared B");
      for (int k = 0; k < 40; k++) step(k[0] ? 16'h0011 : 16'h0022, k[1], "R3 R5 interleaved");
   endtask

   task automatic t_saturate();
      do_reset();
      for (int k = 0; k < 20; k++) step(16'h00F0, 1'b1, "R6 saturate up");
      step(16'h00F0, 1'b0, "R6 single not-taken");
      step(16'h00F0, 1'b1, "R6 after dip");
      for (int k = 0; k < 20; k++) step(16'h00F0, 1'b0, "R6 saturate down");
   endtask

   task automatic t_hold();
      logic exp;
      do_reset();
      for (int k = 0; k < 10; k++) step(16'h0077, 1'b1, "R2 train");
      @(negedge clk);
      pred_addr = 16'h0077;
      exp = m_predict(16'h0077);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         #1 check(pred_taken, exp, "R8 R2 hold without update");
      end
      // Same-cycle update: lookup shows pre-update state
      @(negedge clk);
      upd_addr = 16'h0077; upd_taken = 1'b0; upd_valid = 1'b1;
      #1 check(pred_taken, exp, "R8 same-cycle lookup");
      @(posedge clk);
      m_update(16'h0077, 1'b0);
      #1 upd_valid = 1'b0;
      #1 check(pred_taken, m_predict(16'h0077), "R8 next-cycle effect");
   endtask

   initial begin
      t_reset_state();
      t_loop_trace();
      t_alternating();
      t_shared_pattern();
      t_saturate();
      t_hold();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule